// File: doc/BRIEF.md
# Power Mode State Controller

This block decides which rail groups of a multi-rail supply device are switched on for a processor load. The load has an MCU domain, a main domain and two kinds of retention rails. The controller follows an ON request, a small set of numbered mode triggers, a fault indication and a supply-good flag. From these it drives a per-group rail-enable vector and an enable-drive output. It also exposes its state code so that the surrounding logic can see it.

When a fault takes the controller out of its mission modes, it hands control to an external hardware recovery machine and waits for that machine to return. The first handover after reset, and every later return, starts a fixed four-step configuration routine. The routine turns off the residual-voltage checks, marks first start-up as done and unmasks supply monitoring. After the routine, the controller waits with every rail dark for an ON request. A separate SoC-error mode keeps only the MCU rails on and accepts exactly one way out. Retention comes in two variants, and two select bits pick between them. The controller samples these bits at the moment the retention trigger is accepted.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted, the controller shows the following. `state_o` is 7 (INIT) and `init_step_o` is 0. `rail_en` is 0 and `en_drv` and `recovery_req` are 0. `buck_rv_off`, `ldo_rv_off` and `first_done` are 0. Both supply mask bits are 1. Reset acts at once, without waiting for a clock edge.
- R2: The routine starts two clocks after reset is released, or in the cycle after a return from recovery. In INIT, one step runs per clock and `init_step_o` shows the step that is running. The steps run in this order: step 0 sets `buck_rv_off`, step 1 sets `ldo_rv_off`, step 2 sets `first_done`, and step 3 clears both supply mask bits. After step 3, the controller moves to STANDBY (0) if the routine followed reset, or to WAIT4ENABLE (1) if it followed a recovery return.
- R3: In STANDBY (0) and WAIT4ENABLE (1), `rail_en` is 0 and `en_drv` is low. An ON request in either state moves the controller to ACTIVE (2) on the next clock. An ON request seen during INIT is ignored.
- R4: The `rail_en` bits map as follows: bit 0 is MCU, bit 1 is main, bit 2 is GPIO retention and bit 3 is DDR retention. ACTIVE (2) drives 0011. MCU_ONLY (3) and SOC_ERROR (4) drive 0001. `en_drv` is high in exactly these three states.
- R5: `trig[0]` is trigger A, `trig[1]` is B, `trig[2]` is C and `trig[3]` is D. The legal moves are:
  - ACTIVE: B goes to MCU_ONLY, C goes to SOC_ERROR, D goes to RETENTION (5).
  - MCU_ONLY: A goes to ACTIVE, D goes to RETENTION.
  - RETENTION: A goes to ACTIVE, B goes to MCU_ONLY.
- R6: In SOC_ERROR, trigger B moves the controller to MCU_ONLY. Every other trigger leaves the state and the outputs unchanged.
- R7: Only the lowest-numbered asserted trigger is considered. If that trigger is illegal in the current state, nothing changes, even when a higher-numbered asserted trigger would have been legal. A fault takes precedence over any trigger.
- R8: Accepting D captures `ret_gpio_sel` and `ret_ddr_sel`. In RETENTION, `rail_en` bit 2 equals the captured GPIO select and bit 3 equals the captured DDR select. Bits 0 and 1 are 0 and `en_drv` is low. Changes to the select inputs after capture have no effect.
- R9: A fault is `fault_in` high or `supply_ok` low. A fault in any state other than INIT or RECOVERY moves the controller to RECOVERY (6) on the next clock. In RECOVERY, `rail_en` is 0, `en_drv` is low and `recovery_req` is high. Entering RECOVERY clears both residual-check-off flags and sets both mask bits.
- R10: `hw_return` in RECOVERY moves the controller to INIT on the next clock. The routine then ends in WAIT4ENABLE, and `first_done` stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | ON request |
| trig | input | NTRIG (4) | Mode triggers A..D, bit 0 = A |
| fault_in | input | 1 | Error indication |
| supply_ok | input | 1 | Supply above undervoltage threshold |
| ret_gpio_sel | input | 1 | Selects GPIO retention |
| ret_ddr_sel | input | 1 | Selects DDR retention |
| hw_return | input | 1 | Hardware recovery machine hands control back |
| rail_en | output | 4 | Rail group enables {DDR, GPIO, main, MCU} |
| en_drv | output | 1 | Enable-drive output |
| recovery_req | output | 1 | Control handed to hardware recovery |
| state_o | output | 3 | Current mode code |
| init_step_o | output | 2 | Initialization step in progress |
| init_busy | output | 1 | Initialization routine running |
| buck_rv_off | output | 1 | Buck residual-voltage checks disabled |
| ldo_rv_off | output | 1 | LDO residual-voltage checks disabled |
| first_done | output | 1 | First start-up completed |
| sup_ov_mask | output | 1 | Supply overvoltage mask |
| sup_uv_mask | output | 1 | Supply undervoltage mask |

## Verification
The rail vector and `en_drv` are decoded directly from the state register, so a wrong state code shows up on `rail_en` in the same cycle the state is taken. No delayed effect needs to be waited for. A wrongly accepted or wrongly dropped trigger therefore becomes visible one clock after the stimulus. A stale retention capture or a skipped or reordered routine step shows on the flag outputs within the four INIT cycles. The bench compares the state code, rails and drive against its own expected values after every stimulus vector. It follows each flag clock by clock through both kinds of initialization.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_STANDBY = 3'd0,
    ST_WAIT    = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_MCU     = 3'd3,
    ST_SOCERR  = 3'd4,
    ST_RET     = 3'd5,
    ST_RECOV   = 3'd6,
    ST_INIT    = 3'd7
  } pm_state_e;

  localparam int NRAIL     = 4;
  localparam int RAIL_MCU  = 0;
  localparam int RAIL_MAIN = 1;
  localparam int RAIL_GPIO = 2;
  localparam int RAIL_DDR  = 3;

  localparam int NSTEP  = 4;
  localparam int STEP_W = $clog2(NSTEP);

  localparam int unsigned TRG_A = 0;
  localparam int unsigned TRG_B = 1;
  localparam int unsigned TRG_C = 2;
  localparam int unsigned TRG_D = 3;

endpackage

// File: rtl/pwr_trig_arb.sv
module pwr_trig_arb #(
  parameter int NTRIG = 4,
  localparam int IDX_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic [NTRIG-1:0] trig,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // lowest-numbered asserted trigger wins
  always_comb begin
    hit = |trig;
    idx = '0;
    for (int i = NTRIG - 1; i >= 0; i--) begin
      if (trig[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pwr_init_seq.sv
module pwr_init_seq
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              reload,
  output logic [STEP_W-1:0] step_o,
  output logic              last_o,
  output logic              buck_off_o,
  output logic              ldo_off_o,
  output logic              first_done_o,
  output logic              ov_mask_o,
  output logic              uv_mask_o
);

  logic [STEP_W-1:0] step_q, step_d;
  logic              buck_q, ldo_q, first_q, ovm_q, uvm_q;
  logic              buck_d, ldo_d, first_d, ovm_d, uvm_d;
  logic              cfg_en;

  assign last_o = run && (step_q == STEP_W'(NSTEP - 1));

  always_comb begin
    step_d  = run ? (last_o ? '0 : step_q + STEP_W'(1)) : '0;
    buck_d  = buck_q;
    ldo_d   = ldo_q;
    first_d = first_q;
    ovm_d   = ovm_q;
    uvm_d   = uvm_q;
    if (reload) begin
      buck_d = 1'b0;
      ldo_d  = 1'b0;
      ovm_d  = 1'b1;
      uvm_d  = 1'b1;
    end else if (run) begin
      case (step_q)
        STEP_W'(0): buck_d  = 1'b1;
        STEP_W'(1): ldo_d   = 1'b1;
        STEP_W'(2): first_d = 1'b1;
        default: begin
          ovm_d = 1'b0;
          uvm_d = 1'b0;
        end
      endcase
    end
  end

  assign cfg_en = run || reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      buck_q  <= 1'b0;
      ldo_q   <= 1'b0;
      first_q <= 1'b0;
      ovm_q   <= 1'b1;
      uvm_q   <= 1'b1;
    end else begin
      step_q <= step_d;
      if (cfg_en) begin
        buck_q  <= buck_d;
        ldo_q   <= ldo_d;
        first_q <= first_d;
        ovm_q   <= ovm_d;
        uvm_q   <= uvm_d;
      end
    end
  end

  assign step_o       = step_q;
  assign buck_off_o   = buck_q;
  assign ldo_off_o    = ldo_q;
  assign first_done_o = first_q;
  assign ov_mask_o    = ovm_q;
  assign uv_mask_o    = uvm_q;

endmodule

// File: rtl/pwr_rail_dec.sv
module pwr_rail_dec
  import pwr_mode_pkg::*;
(
  input  pm_state_e        state,
  input  logic [1:0]       ret_sel,
  output logic [NRAIL-1:0] rail_en,
  output logic             en_drv,
  output logic             recovery_req
);

  always_comb begin
    rail_en      = '0;
    en_drv       = 1'b0;
    recovery_req = 1'b0;
    case (state)
      ST_ACTIVE: begin
        rail_en[RAIL_MCU]  = 1'b1;
        rail_en[RAIL_MAIN] = 1'b1;
        en_drv             = 1'b1;
      end
      ST_MCU, ST_SOCERR: begin
        rail_en[RAIL_MCU] = 1'b1;
        en_drv            = 1'b1;
      end
      ST_RET: begin
        rail_en[RAIL_GPIO] = ret_sel[0];
        rail_en[RAIL_DDR]  = ret_sel[1];
      end
      ST_RECOV: recovery_req = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NTRIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_req,
  input  logic [NTRIG-1:0]  trig,
  input  logic              fault_in,
  input  logic              supply_ok,
  input  logic              ret_gpio_sel,
  input  logic              ret_ddr_sel,
  input  logic              hw_return,
  output logic [NRAIL-1:0]  rail_en,
  output logic              en_drv,
  output logic              recovery_req,
  output logic [2:0]        state_o,
  output logic [STEP_W-1:0] init_step_o,
  output logic              init_busy,
  output logic              buck_rv_off,
  output logic              ldo_rv_off,
  output logic              first_done,
  output logic              sup_ov_mask,
  output logic              sup_uv_mask
);

  localparam int TIDX_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;

  // reset: asserts at once, releases after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  pm_state_e         state_q, state_d;
  logic              dest_wait_q, dest_wait_d;
  logic [1:0]        ret_sel_q;
  logic              ret_cap, st_upd, dest_en;
  logic              fault, trig_hit, init_last, init_reload;
  logic [TIDX_W-1:0] trig_idx;
  int unsigned       tn;

  assign fault = fault_in || !supply_ok;

  pwr_trig_arb #(.NTRIG(NTRIG)) u_arb (
    .trig (trig),
    .hit  (trig_hit),
    .idx  (trig_idx)
  );

  // next-state process
  always_comb begin
    state_d     = state_q;
    dest_wait_d = dest_wait_q;
    ret_cap     = 1'b0;
    tn          = 32'(trig_idx);
    case (state_q)
      ST_INIT: begin
        if (init_last) state_d = dest_wait_q ? ST_WAIT : ST_STANDBY;
      end
      ST_RECOV: begin
        if (hw_return) begin
          state_d     = ST_INIT;
          dest_wait_d = 1'b1;
        end
      end
      default: begin
        if (fault) begin
          state_d = ST_RECOV;
        end else if (state_q == ST_STANDBY || state_q == ST_WAIT) begin
          if (on_req) state_d = ST_ACTIVE;
        end else if (trig_hit) begin
          case (state_q)
            ST_ACTIVE: begin
              if (tn == TRG_B)      state_d = ST_MCU;
              else if (tn == TRG_C) state_d = ST_SOCERR;
              else if (tn == TRG_D) begin
                state_d = ST_RET;
                ret_cap = 1'b1;
              end
            end
            ST_MCU: begin
              if (tn == TRG_A)      state_d = ST_ACTIVE;
              else if (tn == TRG_D) begin
                state_d = ST_RET;
                ret_cap = 1'b1;
              end
            end
            ST_SOCERR: begin
              if (tn == TRG_B) state_d = ST_MCU;
            end
            ST_RET: begin
              if (tn == TRG_A)      state_d = ST_ACTIVE;
              else if (tn == TRG_B) state_d = ST_MCU;
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  assign st_upd      = (state_d != state_q);
  assign dest_en     = (state_q == ST_RECOV);
  assign init_reload = st_upd && (state_d == ST_RECOV);

  // register process
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q     <= ST_INIT;
      dest_wait_q <= 1'b0;
      ret_sel_q   <= '0;
    end else begin
      if (st_upd)  state_q     <= state_d;
      if (dest_en) dest_wait_q <= dest_wait_d;
      if (ret_cap) ret_sel_q   <= {ret_ddr_sel, ret_gpio_sel};
    end
  end

  pwr_init_seq u_init (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .run          (state_q == ST_INIT),
    .reload       (init_reload),
    .step_o       (init_step_o),
    .last_o       (init_last),
    .buck_off_o   (buck_rv_off),
    .ldo_off_o    (ldo_rv_off),
    .first_done_o (first_done),
    .ov_mask_o    (sup_ov_mask),
    .uv_mask_o    (sup_uv_mask)
  );

  pwr_rail_dec u_dec (
    .state        (state_q),
    .ret_sel      (ret_sel_q),
    .rail_en      (rail_en),
    .en_drv       (en_drv),
    .recovery_req (recovery_req)
  );

  assign state_o   = state_q;
  assign init_busy = (state_q == ST_INIT);

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hw_return,
  input logic [2:0]        state_o,
  input logic [NRAIL-1:0]  rail_en,
  input logic              en_drv,
  input logic [STEP_W-1:0] init_step_o,
  input logic              init_busy
);

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_STANDBY || state_o == ST_WAIT) |-> (rail_en == '0 && !en_drv)); // R3

  AST_FULL_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_ACTIVE) |-> (rail_en == 4'b0011 && en_drv)); // R4

  AST_SOC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SOCERR) |=> (state_o == ST_SOCERR || state_o == ST_MCU || state_o == ST_RECOV)); // R6

  AST_RET_DRV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RET) |-> (!en_drv && rail_en[1:0] == 2'b00)); // R8

  AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RET && $past(state_o) == ST_RET) |-> $stable(rail_en)); // R8

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy && init_step_o != '0) |-> (init_step_o == STEP_W'($past(init_step_o) + 1'b1))); // R2

  AST_RECOV_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RECOV) |-> (rail_en == '0 && !en_drv)); // R9

  AST_RECOV_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RECOV && hw_return) |=> (state_o == ST_INIT)); // R10

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (.*);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;

  localparam int CLK_PER = 10;

  logic       clk, rst_n, on_req, fault_in, supply_ok;
  logic       ret_gpio_sel, ret_ddr_sel, hw_return;
  logic [3:0] trig;
  logic [3:0] rail_en;
  logic       en_drv, recovery_req, init_busy;
  logic [2:0] state_o;
  logic [1:0] init_step_o;
  logic       buck_rv_off, ldo_rv_off, first_done, sup_ov_mask, sup_uv_mask;

  int n_chk = 0;
  int n_fail = 0;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .trig(trig), .fault_in(fault_in),
    .supply_ok(supply_ok), .ret_gpio_sel(ret_gpio_sel), .ret_ddr_sel(ret_ddr_sel),
    .hw_return(hw_return), .rail_en(rail_en), .en_drv(en_drv),
    .recovery_req(recovery_req), .state_o(state_o), .init_step_o(init_step_o),
    .init_busy(init_busy), .buck_rv_off(buck_rv_off), .ldo_rv_off(ldo_rv_off),
    .first_done(first_done), .sup_ov_mask(sup_ov_mask), .sup_uv_mask(sup_uv_mask)
  );

  initial clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  typedef struct packed {
    logic       on;
    logic [3:0] trg;
    logic       err;
    logic       sup;
    logic       gs;
    logic       ds;
    logic       hw;
    logic [2:0] st;
    logic [3:0] rail;
    logic       drv;
  } vec_t;

  // applied one per clock starting from STANDBY
  localparam vec_t VEC [20] = '{
    '{1'b1, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 4'b0011, 1'b1}, // R3 on -> ACTIVE
    '{1'b0, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 4'b0001, 1'b1}, // R5 B -> MCU
    '{1'b0, 4'b0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 4'b0011, 1'b1}, // R5 A -> ACTIVE
    '{1'b0, 4'b0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 4'b0001, 1'b1}, // R5 C -> SOC_ERROR
    '{1'b0, 4'b0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 4'b0001, 1'b1}, // R6 A ignored
    '{1'b0, 4'b1000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 4'b0001, 1'b1}, // R6 D ignored
    '{1'b0, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 4'b0001, 1'b1}, // R6 B -> MCU
    '{1'b0, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 4'b0001, 1'b1}, // R7 B illegal in MCU
    '{1'b0, 4'b0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 4'b0001, 1'b1}, // R7 C illegal in MCU
    '{1'b0, 4'b1000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd5, 4'b0100, 1'b0}, // R8 GPIO retention
    '{1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5, 4'b0100, 1'b0}, // R8 late select ignored
    '{1'b0, 4'b0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd5, 4'b0100, 1'b0}, // R7 C illegal in RET
    '{1'b0, 4'b0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 4'b0011, 1'b1}, // R5 RET A -> ACTIVE
    '{1'b0, 4'b1010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 4'b0001, 1'b1}, // R7 B beats D
    '{1'b0, 4'b1100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 4'b0001, 1'b1}, // R7 C lowest, illegal
    '{1'b0, 4'b1000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd5, 4'b1100, 1'b0}, // R8 both retention
    '{1'b0, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 4'b0001, 1'b1}, // R5 RET B -> MCU
    '{1'b0, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6, 4'b0000, 1'b0}, // R7 R9 fault beats A
    '{1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6, 4'b0000, 1'b0}, // R9 held in RECOVERY
    '{1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd7, 4'b0000, 1'b0}  // R10 return -> INIT
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    on_req = 1'b0; trig = '0; fault_in = 1'b0; supply_ok = 1'b1;
    ret_gpio_sel = 1'b0; ret_ddr_sel = 1'b0; hw_return = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);

    // R1 reset values
    check("R1 state", int'(state_o), 7);
    check("R1 step", int'(init_step_o), 0);
    check("R1 rails", int'(rail_en), 0);
    check("R1 drv", int'(en_drv), 0);
    check("R1 recov", int'(recovery_req), 0);
    check("R1 flags", int'({buck_rv_off, ldo_rv_off, first_done}), 0);
    check("R1 masks", int'({sup_ov_mask, sup_uv_mask}), 3);

    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 held during sync", int'({state_o, init_step_o}), 28);
    @(negedge clk);
    check("R2 step0 buck", int'({buck_rv_off, ldo_rv_off, first_done}), 4);
    check("R2 step idx 1", int'(init_step_o), 1);
    @(negedge clk);
    check("R2 step1 ldo", int'({buck_rv_off, ldo_rv_off, first_done}), 6);
    check("R2 step idx 2", int'(init_step_o), 2);
    @(negedge clk);
    check("R2 step2 first", int'({buck_rv_off, ldo_rv_off, first_done}), 7);
    check("R2 masks still set", int'({sup_ov_mask, sup_uv_mask}), 3);
    @(negedge clk);
    check("R2 masks cleared", int'({sup_ov_mask, sup_uv_mask}), 0);
    check("R2 lands STANDBY", int'(state_o), 0);
    check("R3 standby dark", int'({rail_en, en_drv}), 0);

    for (int i = 0; i < 20; i++) begin
      on_req = VEC[i].on; trig = VEC[i].trg; fault_in = VEC[i].err;
      supply_ok = VEC[i].sup; ret_gpio_sel = VEC[i].gs;
      ret_ddr_sel = VEC[i].ds; hw_return = VEC[i].hw;
      @(negedge clk);
      check($sformatf("R5 R6 R7 R8 state vec %0d", i), int'(state_o), int'(VEC[i].st));
      check($sformatf("R4 R8 rails vec %0d", i), int'(rail_en), int'(VEC[i].rail));
      check($sformatf("R4 drv vec %0d", i), int'(en_drv), int'(VEC[i].drv));
    end

    // now in INIT after a recovery return
    idle_inputs();
    on_req = 1'b1;
    check("R9 checks re-armed", int'({buck_rv_off, ldo_rv_off}), 0);
    check("R9 masks re-set", int'({sup_ov_mask, sup_uv_mask}), 3);
    check("R10 first_done kept", int'(first_done), 1);
    repeat (3) @(negedge clk);
    check("R2 re-init step3", int'(init_step_o), 3);
    check("R2 re-init flags", int'({buck_rv_off, ldo_rv_off, first_done}), 7);
    @(negedge clk);
    check("R10 lands WAIT", int'(state_o), 1);
    check("R3 on ignored in INIT", int'({rail_en, en_drv}), 0);
    @(negedge clk);
    check("R3 WAIT on -> ACTIVE", int'(state_o), 2);

    on_req = 1'b0;
    supply_ok = 1'b0;
    @(negedge clk);
    check("R9 supply loss", int'(state_o), 6);
    check("R9 recovery_req", int'(recovery_req), 1);

    supply_ok = 1'b1;
    hw_return = 1'b1;
    @(negedge clk);
    hw_return = 1'b0;
    check("R10 INIT again", int'(state_o), 7);
    repeat (4) @(negedge clk);
    check("R10 WAIT again", int'(state_o), 1);
    supply_ok = 1'b0;
    @(negedge clk);
    check("R9 fault in WAIT", int'(state_o), 6);

    supply_ok = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    check("R1 async reset", int'(state_o), 7);
    check("R1 async masks", int'({sup_ov_mask, sup_uv_mask}), 3);
    check("R1 async first_done", int'(first_done), 0);

    finish_run();
  end

endmodule